// File: doc/BRIEF.md
# Descriptor Fetch Channel Sequencer

This block runs cryptographic tasks one at a time for a host. The host queues tasks by writing descriptor addresses into a pointer queue. Whenever the channel has no task in hand and the queue holds an entry, the channel takes the oldest address. It reads the descriptor found there, one 64-bit word per request, and keeps the header and the sizes word.

From the header the channel learns which execution unit is the primary and whether a second unit takes part. It asks the central arbiter for every unit it needs. If a second unit takes part, the channel tells that unit, through a register write, to snoop the primary's input or output stream. It then waits until every assigned unit reports that its reset sequence is over. Only then does it program the units:

- the mode of the primary unit;
- the mode of the secondary unit, when there is one;
- the key size of the primary unit;
- the data size of the primary unit.

A one-cycle done pulse closes the task, the unit requests are dropped, and the next queued address is served.

Top module: `desc_chan`

## Requirements
- R1: While reset is held and right after it, `mem_rd_req`, `arb_req`, `reg_wr_en`, `task_done` and `ptr_ovf` are all low.
- R2: The pointer queue stores up to 24 addresses. A write while 24 are stored is discarded and sets `ptr_ovf`. `ptr_ovf` then stays high until reset.
- R3: Queued addresses are served strictly oldest first. A task's register writes and done pulse all come before any write of the next task.
- R4: A descriptor is read as 4 words at addresses base, base+8, base+16 and base+24, in that order. A new read request is raised only after the previous word has returned on `mem_rd_valid`.
- R5: `arb_req` carries a one-hot bit for the primary unit, plus a bit for the secondary unit when it is enabled. It stays constant until the done pulse. No register write happens before every requested bit is granted.
- R6: With the secondary unit enabled, the first write of the task goes to the secondary unit with select 1 (snoop). Its data carries the primary unit index in bits [1:0] and the direction in bit 8 (1 = output stream, 0 = input stream).
- R7: Mode writes (select 0) go out only once `unit_rst_done` is high for every requested unit. The primary's mode goes first, then the secondary's mode when that unit is enabled.
- R8: After the mode writes, two writes go to the primary unit: first the key size with select 2, then the data size with select 3.
- R9: `task_done` is a single-cycle pulse in the cycle after the data-size write, and `arb_req` is zero in that cycle.
- R10: Header word 0 fields:
  - bits [1:0]: primary unit;
  - bits [3:2]: secondary unit;
  - bit 4: secondary enable;
  - bit 5: snoop direction;
  - bits [15:8]: primary mode;
  - bits [23:16]: secondary mode.

  Word 1 holds the key size in bits [31:0] and the data size in bits [63:32]. All other bits and words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Pushes one descriptor address |
| ptr_wr_data | input | 32 | Descriptor address to queue |
| ptr_ovf | output | 1 | Sticky flag: a push was lost on a full queue |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Address of the word requested |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 64 | Returned descriptor word |
| arb_req | output | 4 | Units requested from the arbiter |
| arb_gnt | input | 4 | Units granted by the arbiter |
| unit_rst_done | input | 4 | Per-unit reset-sequence complete |
| reg_wr_en | output | 1 | Unit register write strobe |
| reg_wr_unit | output | 2 | Target unit index |
| reg_wr_sel | output | 2 | Register select: 0 mode, 1 snoop, 2 key size, 3 data size |
| reg_wr_data | output | 32 | Register write data |
| task_done | output | 1 | One-cycle end-of-task pulse |

## Verification
Read requests are answered 1 to 3 cycles after they are seen, and the address is compared on the cycle the request is raised. No register write has a fixed cycle count from the pointer push, because it depends on read latency, on grant timing and on each unit's reset delay (2 cycles plus the unit index after grant). For that reason the scoreboard compares every write and every done pulse in order, on the falling edge of the cycle where the strobe is high, rather than at a predicted cycle. The overflow flag is sampled one falling edge after the discarded push. Stall checks hold the grant back for a known window and then confirm that no write came out during it.

// File: rtl/chan_pkg.sv
package chan_pkg;
    localparam int WORD_W     = 64;
    localparam int REG_W      = 32;
    localparam int MODE_P_LSB = 8;
    localparam int MODE_S_LSB = 16;
    localparam int MODE_W     = 8;
    localparam int KEY_LSB    = 0;
    localparam int SIZE_LSB   = 32;
    localparam int SNOOP_DIR  = 8;
    localparam int HDR_WORDS  = 2;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_SNOOP = 2'd1,
        SEL_KEY   = 2'd2,
        SEL_DSIZE = 2'd3
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_REQ,
        ST_SNOOP,
        ST_WAIT_RST,
        ST_MODE_P,
        ST_MODE_S,
        ST_KEY,
        ST_DSIZE,
        ST_DONE
    } chan_st_e;
endpackage

// File: rtl/chan_ptr_fifo.sv
module chan_ptr_fifo #(
    parameter int DEPTH = 24,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         ovf
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_s;

    fifo_s      s_d, s_q;
    logic [W-1:0] slot_q [DEPTH];
    logic       full, push_ok, pop_ok;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (s_q.cnt == CNT_W'(DEPTH));
        empty   = (s_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        s_d     = s_q;
        if (push_ok) s_d.wr = wrap_inc(s_q.wr);
        if (pop_ok)  s_d.rd = wrap_inc(s_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (push && full) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) slot_q[s_q.wr] <= push_data;
    end

    assign head = slot_q[s_q.rd];
    assign ovf  = s_q.ovf;
endmodule

// File: rtl/chan_desc_store.sv
module chan_desc_store
    import chan_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [$clog2(WORDS)-1:0]              wr_idx,
    input  logic [WORD_W-1:0]                     wr_data,
    output logic [HDR_WORDS-1:0][WORD_W-1:0]      hdr_words
);
    localparam int IDX_W = $clog2(WORDS);

    // Only the leading header words are kept; later words pass by unstored.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wr_en && (wr_idx == IDX_W'(g))) w_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end

        assign hdr_words[g] = w_q;
    end
endmodule

// File: rtl/chan_ctrl_fsm.sv
module chan_ctrl_fsm
    import chan_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORDS     = 4,
    parameter int NUM_UNITS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fifo_empty,
    input  logic [ADDR_W-1:0]                  fifo_head,
    output logic                               fifo_pop,
    output logic                               mem_rd_req,
    output logic [ADDR_W-1:0]                  mem_rd_addr,
    input  logic                               mem_rd_valid,
    output logic                               st_wr_en,
    output logic [$clog2(WORDS)-1:0]           st_wr_idx,
    input  logic [HDR_WORDS-1:0][WORD_W-1:0]   hdr_words,
    output logic [NUM_UNITS-1:0]               arb_req,
    input  logic [NUM_UNITS-1:0]               arb_gnt,
    input  logic [NUM_UNITS-1:0]               unit_rst_done,
    output logic                               reg_wr_en,
    output logic [$clog2(NUM_UNITS)-1:0]       reg_wr_unit,
    output logic [1:0]                         reg_wr_sel,
    output logic [REG_W-1:0]                   reg_wr_data,
    output logic                               task_done
);
    localparam int IDX_W  = $clog2(WORDS);
    localparam int UNIT_W = $clog2(NUM_UNITS);

    typedef struct packed {
        chan_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
    } fsm_s;

    fsm_s s_d, s_q;

    logic [UNIT_W-1:0]    pri_sel, sec_sel;
    logic                 sec_en, snp_dir;
    logic [MODE_W-1:0]    mode_p, mode_s;
    logic [REG_W-1:0]     key_size, data_size, snoop_word;
    logic [NUM_UNITS-1:0] need;
    logic                 all_gnt, all_rst, holding;
    logic                 unused_hdr_parity;

    // Header decode
    always_comb begin
        pri_sel   = hdr_words[0][UNIT_W-1:0];
        sec_sel   = hdr_words[0][2*UNIT_W-1:UNIT_W];
        sec_en    = hdr_words[0][2*UNIT_W];
        snp_dir   = hdr_words[0][2*UNIT_W+1];
        mode_p    = hdr_words[0][MODE_P_LSB +: MODE_W];
        mode_s    = hdr_words[0][MODE_S_LSB +: MODE_W];
        key_size  = hdr_words[1][KEY_LSB +: REG_W];
        data_size = hdr_words[1][SIZE_LSB +: REG_W];
        snoop_word                 = '0;
        snoop_word[UNIT_W-1:0]     = pri_sel;
        snoop_word[SNOOP_DIR]      = snp_dir;
        need          = '0;
        need[pri_sel] = 1'b1;
        if (sec_en) need[sec_sel] = 1'b1;
        all_gnt = ((arb_gnt & need) == need);
        all_rst = ((unit_rst_done & need) == need);
    end

    assign unused_hdr_parity = ^hdr_words[0];

    always_comb begin
        s_d         = s_q;
        fifo_pop    = 1'b0;
        mem_rd_req  = 1'b0;
        mem_rd_addr = s_q.base + ADDR_W'({s_q.idx, 3'b000});
        st_wr_en    = 1'b0;
        st_wr_idx   = s_q.idx;
        reg_wr_en   = 1'b0;
        reg_wr_unit = pri_sel;
        reg_wr_sel  = SEL_MODE;
        reg_wr_data = '0;
        task_done   = 1'b0;
        holding     = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    s_d.base = fifo_head;
                    s_d.idx  = '0;
                    s_d.st   = ST_RD_ISSUE;
                end
            end
            ST_RD_ISSUE: begin
                mem_rd_req = 1'b1;
                s_d.st     = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rd_valid) begin
                    st_wr_en = 1'b1;
                    if (s_q.idx == IDX_W'(WORDS - 1)) begin
                        s_d.st = ST_REQ;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = ST_RD_ISSUE;
                    end
                end
            end
            ST_REQ: begin
                holding = 1'b1;
                if (all_gnt) s_d.st = sec_en ? ST_SNOOP : ST_WAIT_RST;
            end
            ST_SNOOP: begin
                holding     = 1'b1;
                reg_wr_en   = 1'b1;
                reg_wr_unit = sec_sel;
                reg_wr_sel  = SEL_SNOOP;
                reg_wr_data = snoop_word;
                s_d.st      = ST_WAIT_RST;
            end
            ST_WAIT_RST: begin
                holding = 1'b1;
                if (all_rst) s_d.st = ST_MODE_P;
            end
            ST_MODE_P: begin
                holding     = 1'b1;
                reg_wr_en   = 1'b1;
                reg_wr_sel  = SEL_MODE;
                reg_wr_data = REG_W'(mode_p);
                s_d.st      = sec_en ? ST_MODE_S : ST_KEY;
            end
            ST_MODE_S: begin
                holding     = 1'b1;
                reg_wr_en   = 1'b1;
                reg_wr_unit = sec_sel;
                reg_wr_sel  = SEL_MODE;
                reg_wr_data = REG_W'(mode_s);
                s_d.st      = ST_KEY;
            end
            ST_KEY: begin
                holding     = 1'b1;
                reg_wr_en   = 1'b1;
                reg_wr_sel  = SEL_KEY;
                reg_wr_data = key_size;
                s_d.st      = ST_DSIZE;
            end
            ST_DSIZE: begin
                holding     = 1'b1;
                reg_wr_en   = 1'b1;
                reg_wr_sel  = SEL_DSIZE;
                reg_wr_data = data_size;
                s_d.st      = ST_DONE;
            end
            ST_DONE: begin
                task_done = 1'b1;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        arb_req = holding ? need : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, base: '0, idx: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/desc_chan.sv
module desc_chan
    import chan_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 24,
    parameter int DESC_WORDS = 4,
    parameter int NUM_UNITS  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ptr_wr_en,
    input  logic [ADDR_W-1:0]            ptr_wr_data,
    output logic                         ptr_ovf,
    output logic                         mem_rd_req,
    output logic [ADDR_W-1:0]            mem_rd_addr,
    input  logic                         mem_rd_valid,
    input  logic [WORD_W-1:0]            mem_rd_data,
    output logic [NUM_UNITS-1:0]         arb_req,
    input  logic [NUM_UNITS-1:0]         arb_gnt,
    input  logic [NUM_UNITS-1:0]         unit_rst_done,
    output logic                         reg_wr_en,
    output logic [$clog2(NUM_UNITS)-1:0] reg_wr_unit,
    output logic [1:0]                   reg_wr_sel,
    output logic [REG_W-1:0]             reg_wr_data,
    output logic                         task_done
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    logic                               fifo_empty, fifo_pop;
    logic [ADDR_W-1:0]                  fifo_head;
    logic                               st_wr_en;
    logic [IDX_W-1:0]                   st_wr_idx;
    logic [HDR_WORDS-1:0][WORD_W-1:0]   hdr_words;

    chan_ptr_fifo #(.DEPTH(FIFO_DEPTH), .W(ADDR_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ptr_wr_en),
        .push_data (ptr_wr_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .ovf       (ptr_ovf)
    );

    chan_desc_store #(.WORDS(DESC_WORDS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr_en),
        .wr_idx    (st_wr_idx),
        .wr_data   (mem_rd_data),
        .hdr_words (hdr_words)
    );

    chan_ctrl_fsm #(.ADDR_W(ADDR_W), .WORDS(DESC_WORDS), .NUM_UNITS(NUM_UNITS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_empty    (fifo_empty),
        .fifo_head     (fifo_head),
        .fifo_pop      (fifo_pop),
        .mem_rd_req    (mem_rd_req),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_valid  (mem_rd_valid),
        .st_wr_en      (st_wr_en),
        .st_wr_idx     (st_wr_idx),
        .hdr_words     (hdr_words),
        .arb_req       (arb_req),
        .arb_gnt       (arb_gnt),
        .unit_rst_done (unit_rst_done),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_unit   (reg_wr_unit),
        .reg_wr_sel    (reg_wr_sel),
        .reg_wr_data   (reg_wr_data),
        .task_done     (task_done)
    );
endmodule

// File: rtl/desc_chan_chk.sv
module desc_chan_chk
    import chan_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ptr_ovf,
    input logic                         mem_rd_req,
    input logic                         mem_rd_valid,
    input logic [NUM_UNITS-1:0]         arb_req,
    input logic [NUM_UNITS-1:0]         arb_gnt,
    input logic [NUM_UNITS-1:0]         unit_rst_done,
    input logic                         reg_wr_en,
    input logic [$clog2(NUM_UNITS)-1:0] reg_wr_unit,
    input logic [1:0]                   reg_wr_sel,
    input logic                         task_done
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            out_q <= 1'b0;
        else if (mem_rd_req)   out_q <= 1'b1;
        else if (mem_rd_valid) out_q <= 1'b0;
    end

    p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ovf |=> ptr_ovf);

    p_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !out_q);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req != '0) |=> ((arb_req == $past(arb_req)) || ((arb_req == '0) && task_done)));

    p_wr_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (arb_gnt[reg_wr_unit] && arb_req[reg_wr_unit]));

    p_mode_after_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_wr_sel == SEL_MODE)) |-> unit_rst_done[reg_wr_unit]);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        task_done |=> !task_done);

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        task_done |-> (arb_req == '0 && !reg_wr_en));
endmodule

bind desc_chan desc_chan_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ptr_ovf       (ptr_ovf),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_valid  (mem_rd_valid),
    .arb_req       (arb_req),
    .arb_gnt       (arb_gnt),
    .unit_rst_done (unit_rst_done),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_unit   (reg_wr_unit),
    .reg_wr_sel    (reg_wr_sel),
    .task_done     (task_done)
);

// File: tb/test_desc_chan.sv
module test_desc_chan;
    import chan_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ptr_wr_en;
    logic [31:0] ptr_wr_data;
    logic        ptr_ovf;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_data;
    logic [3:0]  arb_req, arb_gnt, unit_rst_done;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_unit, reg_wr_sel;
    logic [31:0] reg_wr_data;
    logic        task_done;

    always #5 clk = ~clk;

    desc_chan i_desc_chan (
        .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .ptr_ovf(ptr_ovf), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .arb_req(arb_req),
        .arb_gnt(arb_gnt), .unit_rst_done(unit_rst_done), .reg_wr_en(reg_wr_en),
        .reg_wr_unit(reg_wr_unit), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .task_done(task_done)
    );

    typedef struct packed {
        logic        is_done;
        logic [1:0]  unit;
        logic [1:0]  sel;
        logic [31:0] data;
    } ev_t;

    ev_t         exp_q[$];
    logic [31:0] addr_q[$];
    logic [63:0] mem_img [logic [31:0]];
    int          checks = 0, fails = 0, n_writes = 0;
    logic [3:0]  gnt_mask = 4'hF;
    bit          timed_out = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: builds the descriptor image, queues expectations, pushes the pointer.
    task automatic push_task(input logic [31:0] ptr, input int pri, input int sec,
                             input bit en, input bit dir, input logic [7:0] pm,
                             input logic [7:0] sm, input logic [31:0] ks,
                             input logic [31:0] ds, input bit dropped);
        logic [63:0] hdr;
        logic [31:0] snp;
        if (!dropped) begin
            hdr        = {40'hC3A5_5A3C_96, 24'h0};
            hdr[1:0]   = 2'(pri);
            hdr[3:2]   = 2'(sec);
            hdr[4]     = en;
            hdr[5]     = dir;
            hdr[7:6]   = 2'b11;
            hdr[15:8]  = pm;
            hdr[23:16] = sm;
            mem_img[ptr]      = hdr;
            mem_img[ptr + 8]  = {ds, ks};
            mem_img[ptr + 16] = 64'hDEAD_BEEF_0000_0000 | 64'(ptr);
            mem_img[ptr + 24] = ~(64'(ptr));
            for (int i = 0; i < 4; i++) addr_q.push_back(ptr + 32'(8 * i));
            snp = '0; snp[1:0] = 2'(pri); snp[8] = dir;
            if (en) exp_q.push_back('{1'b0, 2'(sec), 2'd1, snp});
            exp_q.push_back('{1'b0, 2'(pri), 2'd0, 32'(pm)});
            if (en) exp_q.push_back('{1'b0, 2'(sec), 2'd0, 32'(sm)});
            exp_q.push_back('{1'b0, 2'(pri), 2'd2, ks});
            exp_q.push_back('{1'b0, 2'(pri), 2'd3, ds});
            exp_q.push_back('{1'b1, 2'd0, 2'd0, 32'd0});
        end
        @(posedge clk); #1;
        ptr_wr_en = 1'b1; ptr_wr_data = ptr;
        @(posedge clk); #1;
        ptr_wr_en = 1'b0;
    endtask

    // Memory model: answers each read after 1..3 cycles (R4).
    initial begin
        int wait_cnt, nreads;
        logic [31:0] a, ea;
        wait_cnt = 0; nreads = 0; a = '0;
        mem_rd_valid = 1'b0; mem_rd_data = '0;
        forever begin
            @(posedge clk); #1;
            mem_rd_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem_img.exists(a) ? mem_img[a] : 64'h0;
                end
            end else if (rst_n && mem_rd_req) begin
                a = mem_rd_addr;
                if (addr_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected read", 64'(a), 64'h0);
                end else begin
                    ea = addr_q.pop_front();
                    check(a == ea, "R4", "read address", 64'(a), 64'(ea));
                end
                wait_cnt = 1 + (nreads % 3);
                nreads++;
            end
        end
    end

    // Arbiter and unit reset model: unit u is ready 2+u cycles after its grant.
    initial begin
        int rcnt [4];
        for (int u = 0; u < 4; u++) rcnt[u] = 0;
        arb_gnt = '0; unit_rst_done = '0;
        forever begin
            @(posedge clk); #1;
            arb_gnt = arb_req & gnt_mask;
            for (int u = 0; u < 4; u++) begin
                rcnt[u] = arb_gnt[u] ? rcnt[u] + 1 : 0;
                unit_rst_done[u] = (rcnt[u] >= 2 + u);
            end
        end
    end

    function automatic string sel_tag(input logic [1:0] s);
        case (s)
            2'd0:    return "R7/R10";
            2'd1:    return "R6";
            default: return "R8/R3";
        endcase
    endfunction

    // Monitor: compares each write and done pulse against the scoreboard.
    initial begin
        ev_t e;
        forever begin
            @(negedge clk);
            if (rst_n && reg_wr_en) begin
                n_writes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected write", 64'(reg_wr_data), 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(!e.is_done, "R9", "write where done due", 64'h1, 64'h0);
                    check(reg_wr_unit == e.unit, sel_tag(e.sel), "unit", 64'(reg_wr_unit), 64'(e.unit));
                    check(reg_wr_sel == e.sel, sel_tag(e.sel), "select", 64'(reg_wr_sel), 64'(e.sel));
                    check(reg_wr_data == e.data, sel_tag(e.sel), "data", 64'(reg_wr_data), 64'(e.data));
                    if (reg_wr_sel == 2'd0)
                        check(unit_rst_done[reg_wr_unit], "R7", "mode before reset done",
                              64'(unit_rst_done), 64'hF);
                end
            end
            if (rst_n && task_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 64'h1, 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.is_done, "R9", "done early", 64'h1, 64'(e.is_done));
                end
                check(arb_req == '0, "R9", "requests at done", 64'(arb_req), 64'h0);
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic run_all();
        int w0;
        rst_n = 1'b0; ptr_wr_en = 1'b0; ptr_wr_data = '0;
        repeat (3) @(negedge clk);
        check({mem_rd_req, arb_req, reg_wr_en, task_done, ptr_ovf} == '0, "R1",
              "outputs in reset", 64'({mem_rd_req, arb_req, reg_wr_en, task_done, ptr_ovf}), 64'h0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check({mem_rd_req, arb_req, reg_wr_en, task_done, ptr_ovf} == '0, "R1",
              "outputs after reset", 64'({mem_rd_req, arb_req, reg_wr_en, task_done, ptr_ovf}), 64'h0);

        // Mixed tasks: primary only, secondary on input, secondary on output (R3 R6 R8 R10)
        push_task(32'h0000_1000, 0, 0, 1'b0, 1'b0, 8'h11, 8'h00, 32'd16, 32'd128, 1'b0);
        push_task(32'h0000_1040, 1, 2, 1'b1, 1'b0, 8'h22, 8'h33, 32'd24, 32'd64,  1'b0);
        push_task(32'h0000_2000, 3, 0, 1'b1, 1'b1, 8'h44, 8'h55, 32'd32, 32'd8,   1'b0);
        push_task(32'h0000_3080, 2, 1, 1'b0, 1'b1, 8'hF0, 8'h0F, 32'hFFFF_FFFF, 32'h8000_0001, 1'b0);
        drain();

        // Partial grant stalls programming (R5)
        gnt_mask = 4'b0001;
        push_task(32'h0000_4000, 0, 1, 1'b1, 1'b0, 8'h66, 8'h77, 32'd16, 32'd48, 1'b0);
        repeat (40) @(negedge clk);
        w0 = n_writes;
        repeat (30) @(negedge clk);
        check(n_writes == w0, "R5", "writes while partly granted", 64'(n_writes - w0), 64'h0);
        check(arb_req == 4'b0011, "R5", "request vector", 64'(arb_req), 64'h3);
        gnt_mask = 4'hF;
        drain();

        // Queue capacity and overflow (R2 R3)
        gnt_mask = 4'h0;
        push_task(32'h0001_0000, 1, 0, 1'b0, 1'b0, 8'h01, 8'h00, 32'd16, 32'd16, 1'b0);
        repeat (40) @(negedge clk);
        for (int k = 0; k < 24; k++)
            push_task(32'h0002_0000 + 32'(k * 64), k % 4, (k + 1) % 4, 1'(k % 2), 1'(k % 3 == 0),
                      8'(k + 1), 8'(k + 100), 32'(16 + 8 * (k % 3)), 32'(k * 7 + 1), 1'b0);
        @(negedge clk);
        check(ptr_ovf == 1'b0, "R2", "flag with 24 stored", 64'(ptr_ovf), 64'h0);
        push_task(32'h0009_0000, 0, 0, 1'b0, 1'b0, 8'hEE, 8'h00, 32'd1, 32'd1, 1'b1);
        @(negedge clk);
        check(ptr_ovf == 1'b1, "R2", "flag after lost push", 64'(ptr_ovf), 64'h1);
        gnt_mask = 4'hF;
        drain();
        repeat (50) @(negedge clk);
        check(ptr_ovf == 1'b1, "R2", "flag sticky", 64'(ptr_ovf), 64'h1);
        check(addr_q.size() == 0, "R4", "reads outstanding", 64'(addr_q.size()), 64'h0);
        check(exp_q.size() == 0, "R3", "events outstanding", 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule